// File: doc/BRIEF.md
# Selectable-Width Video Raster Timing Generator

This block produces the horizontal and vertical raster timing of a tile-based video processor. It runs off the master clock and divides it into internal ticks. Two mode bits set the divisor and the line width. Each pixel slot lasts two ticks. The block counts ticks along a line and lines down a frame. From those counts it decodes the horizontal and vertical sync pulses, the active-image flag, the border flag and a one-tick vertical interrupt. It also brings out the tick enable, the pixel and line positions and an interlace field flag, so that downstream fetch logic can follow the raster.

The narrow width is 256 pixels and the wide width is 320 pixels. The wide width with the alternate clock source keeps the narrow line period: during part of the wide sync pulse the divider stretches from four master clocks per tick to five. Mixed mode-bit combinations are still generated, and they give lines of a different length. A tall-image bit extends the image area from the short row count to the tall row count without changing the frame length. The one exception is a tall image on a 60 Hz frame, which is invalid: the frame then takes a fixed odd length and carries neither vertical sync nor vertical interrupt. Mode inputs are taken in only when a line starts, and the first cycle after reset takes them directly.

Top module: `video_timing_gen`

## Requirements
- R1: In the first cycle after reset is released, pix_cnt and line_cnt are 0, active is 1, and hsync, vsync, vint and border are 0.
- R2: tick is high for one master clock in every divisor period. The divisor is 5 when mode_alt=0 and mode_wide=0, and 4 when exactly one of the two bits is set. When both bits are set, the divisor is 5 for tick indices 700 to 759 of a line and 4 for all other indices.
- R3: A line holds 684 ticks when mode_wide=0 and 840 ticks when mode_wide=1, and pix_cnt equals the tick index within the line divided by two. A line therefore lasts 3420 master clocks in mode (alt,wide)=00, 3360 in mode 01, 2736 in mode 10 and 3420 in mode 11.
- R4: hsync is high for tick indices 560 to 611 when mode_wide=0 and for tick indices 700 to 767 when mode_wide=1. That gives 260, 272, 208 and 332 master clocks of sync in modes 00, 01, 10 and 11.
- R5: A frame holds NTSC_LINES lines when pal_sel=0 and PAL_LINES lines when pal_sel=1. line_cnt counts from 0 and returns to 0 after the last line.
- R6: active is high when pix_cnt is below the line width (256 narrow, 320 wide) and line_cnt is below the image row count (ROWS_SHORT, or ROWS_TALL when tall_sel=1). border is high inside the line width on the rows from the image row count up to ROWS_TALL. tall_sel does not change the frame length when pal_sel=1.
- R7: With tall_sel=1 and pal_sel=0, the frame holds BAD_LINES lines and vsync and vint stay low.
- R8: Outside the invalid case, vsync is high on the lines VS_START to VS_START+VS_LEN-1 and low on all others.
- R9: Outside the invalid case, vint is high only during tick index 0 of the line whose number equals the image row count. It stays high for one tick period, which is 4 master clocks in mode 10.
- R10: A change of the mode inputs in the middle of a line does not alter that line; the change takes effect from the next line.
- R11: field toggles at each frame wrap while ilace_sel=1, and it is 0 while ilace_sel=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wide | input | 1 | Selects the 320-pixel width and master/4 ticks |
| mode_alt | input | 1 | Selects the alternate tick source (stretched sync in wide mode) |
| tall_sel | input | 1 | Selects the tall image area |
| pal_sel | input | 1 | 1 for the 50 Hz frame length, 0 for the 60 Hz frame length |
| ilace_sel | input | 1 | Enables field toggling |
| tick | output | 1 | Internal tick enable, one master clock wide |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| active | output | 1 | Pixel lies inside the image area |
| border | output | 1 | Pixel lies in a visible row that carries no image |
| vint | output | 1 | Vertical interrupt pulse, one tick long |
| field | output | 1 | Interlace field flag |
| pix_cnt | output | PIX_W | Pixel slot within the line |
| line_cnt | output | LINE_W | Line within the frame |

## Verification
All four combinations of the mode bits are run over a full line. The bench checks the divisor of every tick against its index, along with the tick count, the line length in master clocks, the sync length and the pixel count. These runs separate the master/5 mode from the master/4 modes, and only the stretched sync window makes mode 11 match the length of mode 00. Full frames at the 60 Hz length, at the 50 Hz length with a tall image and interlace, and in the invalid tall 60 Hz case separate the three frame lengths, the border rows against the image rows, and the suppression of sync and interrupt. A mode switch in the middle of a line shows whether that line keeps its old length.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  typedef struct packed {
    logic alt;
    logic wide;
    logic tall;
    logic pal;
    logic ilace;
  } vtg_cfg_t;

  // master clocks per tick for the current tick
  function automatic int unsigned tick_divisor(input logic alt, input logic wide,
                                               input logic slow);
    if (!alt && !wide) return 5;
    if (alt && wide && slow) return 5;
    return 4;
  endfunction

  function automatic int unsigned line_ticks(input logic wide, input int unsigned narrow_t,
                                             input int unsigned wide_t);
    return wide ? wide_t : narrow_t;
  endfunction

endpackage

// File: rtl/vtg_divider.sv
module vtg_divider
  import vtg_pkg::*;
#(
  parameter int HC_W       = 10,
  parameter int SLOW_START = 700,
  parameter int SLOW_LEN   = 60
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alt,
  input  logic            wide,
  input  logic [HC_W-1:0] hc,
  output logic            tick
);

  logic [2:0] dcnt;
  logic [2:0] div_m1;
  logic       slow;

  assign slow   = alt && wide && (hc >= HC_W'(SLOW_START)) &&
                  (hc < HC_W'(SLOW_START + SLOW_LEN));
  assign div_m1 = 3'(tick_divisor(alt, wide, slow) - 1);
  assign tick   = (dcnt == div_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dcnt <= '0;
    else if (tick) dcnt <= '0;
    else           dcnt <= dcnt + 3'd1;
  end

  assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick) else $error("tick on consecutive clocks");

  assert_dcnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dcnt <= 3'd4) else $error("divider count beyond five clocks");

endmodule

// File: rtl/vtg_hcount.sv
module vtg_hcount
  import vtg_pkg::*;
#(
  parameter int HC_W         = 10,
  parameter int NARROW_TICKS = 684,
  parameter int WIDE_TICKS   = 840,
  parameter int NARROW_PX    = 256,
  parameter int WIDE_PX      = 320,
  parameter int N_HS_START   = 560,
  parameter int N_HS_LEN     = 52,
  parameter int W_HS_START   = 700,
  parameter int W_HS_LEN     = 68
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            wide,
  output logic [HC_W-1:0] hc,
  output logic [HC_W-2:0] pix,
  output logic            line_end,
  output logic            hc_zero,
  output logic            hsync,
  output logic            h_act
);

  logic [HC_W-1:0] last_hc;
  logic [HC_W-1:0] hs_lo;
  logic [HC_W-1:0] hs_hi;

  assign last_hc  = HC_W'(line_ticks(wide, NARROW_TICKS, WIDE_TICKS) - 1);
  assign line_end = tick && (hc == last_hc);
  assign hc_zero  = (hc == '0);
  assign pix      = hc[HC_W-1:1];
  assign h_act    = wide ? (pix < (HC_W-1)'(WIDE_PX)) : (pix < (HC_W-1)'(NARROW_PX));
  assign hs_lo    = wide ? HC_W'(W_HS_START) : HC_W'(N_HS_START);
  assign hs_hi    = wide ? HC_W'(W_HS_START + W_HS_LEN) : HC_W'(N_HS_START + N_HS_LEN);
  assign hsync    = (hc >= hs_lo) && (hc < hs_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hc <= '0;
    else if (line_end) hc <= '0;
    else if (tick)     hc <= hc + 1'b1;
  end

  assert_hc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(hc)) else $error("tick index moved without a tick");

  assert_hc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !line_end) |=> (hc == $past(hc) + 1'b1)) else $error("tick index skipped");

endmodule

// File: rtl/vtg_vcount.sv
module vtg_vcount #(
  parameter int LINE_W     = 9,
  parameter int NTSC_LINES = 262,
  parameter int PAL_LINES  = 313,
  parameter int BAD_LINES  = 255,
  parameter int ROWS_SHORT = 224,
  parameter int ROWS_TALL  = 240,
  parameter int VS_START   = 245,
  parameter int VS_LEN     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_end,
  input  logic              hc_zero,
  input  logic              h_act,
  input  logic              tall,
  input  logic              pal,
  input  logic              ilace,
  output logic [LINE_W-1:0] vc,
  output logic              vsync,
  output logic              active,
  output logic              border,
  output logic              vint,
  output logic              field
);

  logic              bad;
  logic              wrap;
  logic [LINE_W-1:0] last_line;
  logic [LINE_W-1:0] rows;

  assign bad = tall && !pal;

  always_comb begin
    if (bad)      last_line = LINE_W'(BAD_LINES - 1);
    else if (pal) last_line = LINE_W'(PAL_LINES - 1);
    else          last_line = LINE_W'(NTSC_LINES - 1);
    rows = tall ? LINE_W'(ROWS_TALL) : LINE_W'(ROWS_SHORT);
  end

  assign wrap   = line_end && (vc >= last_line);
  assign active = h_act && (vc < rows);
  assign border = h_act && (vc >= rows) && (vc < LINE_W'(ROWS_TALL));
  assign vsync  = !bad && (vc >= LINE_W'(VS_START)) && (vc < LINE_W'(VS_START + VS_LEN));
  assign vint   = !bad && (vc == rows) && hc_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vc    <= '0;
      field <= 1'b0;
    end else if (wrap) begin
      vc    <= '0;
      field <= ilace & ~field;
    end else if (line_end) begin
      vc    <= vc + 1'b1;
    end
  end

  assert_bad_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bad |-> (!vsync && !vint)) else $error("sync or interrupt in invalid frame");

  assert_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(active && border)) else $error("active and border together");

  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && (vc >= last_line)) |=> (vc == '0)) else $error("frame did not wrap");

  assert_vint_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vint) |-> $past(line_end)) else $error("interrupt rose away from a line start");

endmodule

// File: rtl/video_timing_gen.sv
module video_timing_gen
  import vtg_pkg::*;
#(
  parameter int NARROW_TICKS = 684,
  parameter int WIDE_TICKS   = 840,
  parameter int SLOW_TICKS   = 60,
  parameter int NARROW_PX    = 256,
  parameter int WIDE_PX      = 320,
  parameter int N_HS_START   = 560,
  parameter int N_HS_LEN     = 52,
  parameter int W_HS_START   = 700,
  parameter int W_HS_LEN     = 68,
  parameter int NTSC_LINES   = 262,
  parameter int PAL_LINES    = 313,
  parameter int BAD_LINES    = 255,
  parameter int ROWS_SHORT   = 224,
  parameter int ROWS_TALL    = 240,
  parameter int VS_START     = 245,
  parameter int VS_LEN       = 3,
  localparam int HC_W        = $clog2(WIDE_TICKS),
  localparam int PIX_W       = HC_W - 1,
  localparam int MAX_LINES   = (PAL_LINES > NTSC_LINES) ?
                               ((PAL_LINES > BAD_LINES) ? PAL_LINES : BAD_LINES) :
                               ((NTSC_LINES > BAD_LINES) ? NTSC_LINES : BAD_LINES),
  localparam int LINE_W      = $clog2(MAX_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wide,
  input  logic              mode_alt,
  input  logic              tall_sel,
  input  logic              pal_sel,
  input  logic              ilace_sel,
  output logic              tick,
  output logic              hsync,
  output logic              vsync,
  output logic              active,
  output logic              border,
  output logic              vint,
  output logic              field,
  output logic [PIX_W-1:0]  pix_cnt,
  output logic [LINE_W-1:0] line_cnt
);

  vtg_cfg_t        cfg_in;
  vtg_cfg_t        cfg_q;
  vtg_cfg_t        cfg_use;
  logic            started;
  logic            line_end;
  logic            hc_zero;
  logic            h_act;
  logic [HC_W-1:0] hc;

  assign cfg_in  = '{alt: mode_alt, wide: mode_wide, tall: tall_sel,
                     pal: pal_sel, ilace: ilace_sel};
  // first cycle after reset runs straight off the inputs
  assign cfg_use = started ? cfg_q : cfg_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0;
      cfg_q   <= '0;
    end else begin
      started <= 1'b1;
      if (!started || line_end) cfg_q <= cfg_in;
    end
  end

  vtg_divider #(
    .HC_W(HC_W), .SLOW_START(W_HS_START), .SLOW_LEN(SLOW_TICKS)
  ) u_div (
    .clk(clk), .rst_n(rst_n), .alt(cfg_use.alt), .wide(cfg_use.wide),
    .hc(hc), .tick(tick)
  );

  vtg_hcount #(
    .HC_W(HC_W), .NARROW_TICKS(NARROW_TICKS), .WIDE_TICKS(WIDE_TICKS),
    .NARROW_PX(NARROW_PX), .WIDE_PX(WIDE_PX),
    .N_HS_START(N_HS_START), .N_HS_LEN(N_HS_LEN),
    .W_HS_START(W_HS_START), .W_HS_LEN(W_HS_LEN)
  ) u_h (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wide(cfg_use.wide),
    .hc(hc), .pix(pix_cnt), .line_end(line_end), .hc_zero(hc_zero),
    .hsync(hsync), .h_act(h_act)
  );

  vtg_vcount #(
    .LINE_W(LINE_W), .NTSC_LINES(NTSC_LINES), .PAL_LINES(PAL_LINES),
    .BAD_LINES(BAD_LINES), .ROWS_SHORT(ROWS_SHORT), .ROWS_TALL(ROWS_TALL),
    .VS_START(VS_START), .VS_LEN(VS_LEN)
  ) u_v (
    .clk(clk), .rst_n(rst_n), .line_end(line_end), .hc_zero(hc_zero),
    .h_act(h_act), .tall(cfg_use.tall), .pal(cfg_use.pal), .ilace(cfg_use.ilace),
    .vc(line_cnt), .vsync(vsync), .active(active), .border(border),
    .vint(vint), .field(field)
  );

  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !line_end) |=> $stable(cfg_q)) else $error("mode taken mid-line");

endmodule

// File: tb/video_timing_gen_tb.sv
module video_timing_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;
  localparam int NTSC_L = 10, PAL_L = 12, BAD_L = 11;
  localparam int R_SHORT = 4, R_TALL = 6, VS0 = 8, VSN = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_wide = 0, mode_alt = 0, tall_sel = 0, pal_sel = 0, ilace_sel = 0;
  logic tick, hsync, vsync, active, border, vint, field;
  logic [8:0] pix_cnt;
  logic [3:0] line_cnt;
  int n_tests = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  video_timing_gen #(
    .NTSC_LINES(NTSC_L), .PAL_LINES(PAL_L), .BAD_LINES(BAD_L),
    .ROWS_SHORT(R_SHORT), .ROWS_TALL(R_TALL), .VS_START(VS0), .VS_LEN(VSN)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_wide(mode_wide), .mode_alt(mode_alt),
    .tall_sel(tall_sel), .pal_sel(pal_sel), .ilace_sel(ilace_sel),
    .tick(tick), .hsync(hsync), .vsync(vsync), .active(active), .border(border),
    .vint(vint), .field(field), .pix_cnt(pix_cnt), .line_cnt(line_cnt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_div(input bit alt, input bit wide, input int k);
    if (!alt && !wide) return 5;
    if (alt && wide && k >= 700 && k < 760) return 5;
    return 4;
  endfunction

  task automatic do_reset(input bit alt, input bit wide, input bit tall, input bit pal,
                          input bit il);
    rst_n = 1'b0;
    mode_alt = alt; mode_wide = wide; tall_sel = tall; pal_sel = pal; ilace_sel = il;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one full line in a given mode, every tick checked
  task automatic measure_line(input bit alt, input bit wide, input int exp_len,
                              input int exp_hs);
    int k = 0, since = 0, cyc = 0, err = 0, derr = 0, hs = 0;
    int tticks = wide ? 840 : 684;
    int width = wide ? 320 : 256;
    int hlo = wide ? 700 : 560;
    int hhi = wide ? 768 : 612;
    do_reset(alt, wide, 0, 0, 0);
    while (line_cnt == 0 && cyc < 5000) begin
      since++; cyc++;
      if (int'(pix_cnt) != k / 2 || hsync != (k >= hlo && k < hhi) ||
          active != (k / 2 < width)) begin
        if (err == 0) $display("  mismatch at tick %0d pix=%0d hs=%0b act=%0b", k, pix_cnt,
                               hsync, active);
        err++;
      end
      if (hsync) hs++;
      if (tick) begin
        if (since != exp_div(alt, wide, k)) derr++;
        since = 0;
        k++;
      end
      @(negedge clk);
    end
    chk(cyc == exp_len, $sformatf("R3 line clocks mode %0b%0b", alt, wide), cyc, exp_len);
    chk(k == tticks, "R3 ticks per line", k, tticks);
    chk(derr == 0, "R2 tick divisor errors", derr, 0);
    chk(err == 0, "R4 pixel/hsync/active errors", err, 0);
    chk(hs == exp_hs, "R4 hsync clocks", hs, exp_hs);
  endtask

  // one frame plus a few clocks in mode 10
  task automatic run_frame(input bit tall, input bit pal, input bit il);
    bit bad = tall && !pal;
    int nl = bad ? BAD_L : (pal ? PAL_L : NTSC_L);
    int rows = tall ? R_TALL : R_SHORT;
    int k = 0, ln = 0, maxl = 0, post = 0, wrapped = 0;
    int e_ln = 0, e_ab = 0, e_vs = 0, e_vi = 0, e_fd = 0, vi_cyc = 0, vs_cyc = 0;
    bit fld = 0;
    do_reset(1, 0, tall, pal, il);
    while (post < 10) begin
      if (int'(line_cnt) != ln) e_ln++;
      if (int'(line_cnt) > maxl) maxl = int'(line_cnt);
      if (active != (ln < rows && k / 2 < 256) ||
          border != (ln >= rows && ln < R_TALL && k / 2 < 256)) e_ab++;
      if (vsync != (!bad && ln >= VS0 && ln < VS0 + VSN)) e_vs++;
      if (vint != (!bad && ln == rows && k == 0)) e_vi++;
      if (field != fld) e_fd++;
      if (vint) vi_cyc++;
      if (vsync) vs_cyc++;
      if (wrapped) post++;
      if (tick) begin
        if (k == 683) begin
          k = 0;
          if (ln == nl - 1) begin
            ln = 0; wrapped = 1; fld = il ? ~fld : 1'b0;
          end else ln++;
        end else k++;
      end
      @(negedge clk);
    end
    chk(maxl + 1 == nl, "R5 lines per frame", maxl + 1, nl);
    chk(e_ln == 0, "R5 line counter errors", e_ln, 0);
    chk(e_ab == 0, "R6 active/border errors", e_ab, 0);
    chk(e_vs == 0, "R8 vsync errors", e_vs, 0);
    chk(e_vi == 0, "R9 vint errors", e_vi, 0);
    chk(vi_cyc == (bad ? 0 : 4), "R9 vint clocks", vi_cyc, bad ? 0 : 4);
    if (bad) chk(vs_cyc == 0, "R7 vsync clocks in invalid frame", vs_cyc, 0);
    else     chk(vs_cyc == VSN * 2736, "R8 vsync clocks", vs_cyc, VSN * 2736);
    chk(e_fd == 0, "R11 field errors", e_fd, 0);
    chk(field == il, "R11 field after wrap", field, il);
  endtask

  task automatic mid_line_switch();
    int cyc = 0;
    do_reset(0, 0, 0, 0, 0);
    while (line_cnt == 0 && cyc < 5000) begin
      cyc++;
      if (cyc == 1000) mode_wide = 1'b1;
      @(negedge clk);
    end
    chk(cyc == 3420, "R10 line keeps old mode", cyc, 3420);
    cyc = 0;
    while (line_cnt == 1 && cyc < 5000) begin
      cyc++;
      @(negedge clk);
    end
    chk(cyc == 3360, "R10 next line takes new mode", cyc, 3360);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset(0, 0, 0, 0, 0);
    chk(pix_cnt == 0, "R1 pix_cnt after reset", pix_cnt, 0);
    chk(line_cnt == 0, "R1 line_cnt after reset", line_cnt, 0);
    chk(active == 1, "R1 active after reset", active, 1);
    chk({hsync, vsync, vint, border} == 4'b0, "R1 flags after reset",
        {hsync, vsync, vint, border}, 0);
    measure_line(0, 0, 3420, 260);
    measure_line(0, 1, 3360, 272);
    measure_line(1, 0, 2736, 208);
    measure_line(1, 1, 3420, 332);
    mid_line_switch();
    run_frame(0, 0, 0);
    run_frame(1, 0, 0);
    run_frame(1, 1, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule